// File: doc/BRIEF.md
# Temperature Hysteresis Fan Controller

This block sets a cooling fan speed from temperature samples. When the sample strobe fires and no evaluation is in progress, the block accepts an 8-bit signed temperature. It then moves a fan level between 0 and 10. The move is checked against a table of eleven thresholds that grow from 30 °C in 5 °C steps.

Each sample first picks a direction.
- A temperature at or above the threshold of the current level moves the level upward, one step at a time, while the next threshold is also reached.
- Otherwise the level moves downward while the temperature stays below the threshold two positions beneath the current level.

This asymmetry keeps the fan from hunting between neighbouring levels. Each clock carries out one step of this walk.

The block has three outputs besides its registers:
- A PWM output whose duty cycle is 10% per level.
- A one-cycle interrupt at the end of every evaluation.
- A sticky over-temperature flag, set by any sample at or above a limit supplied on a port.

A control register holds a one-shot scan request, an auto-scan enable, the interrupt enable and the over-temperature flag. A fan register holds the level.

Top module: `fan_hyst_ctrl`

## Requirements
- R1: After reset the fan level is 3, the control register reads 0, and busy and irq are low.
- R2: A sample with bit 7 set (a negative value) is evaluated as 0 °C.
- R3: A level above 10, written through the fan register, is cut to 10 before the direction is chosen.
- R4: When the temperature is at or above threshold[level], the level rises while it is below 10 and the temperature is at or above threshold[level+1]. Threshold[i] is 30 + 5·i.
- R5: When the temperature is below threshold[level], the level falls while it is above 1 and the temperature is below threshold[level−2]. Otherwise the level is held.
- R6: Over any 10 consecutive clocks, pwm_out is high for min(level,10) clocks.
- R7: The fan register (wr_addr 1) keeps the level in bits 11:8. All its other bits read 0.
- R8: The control register (wr_addr 0) has scan in bit 0, auto-scan in bit 1 and interrupt enable in bit 2, all read/write. Bit 15 sets when an accepted sample is at or above ot_limit. Only writing a 1 to bit 15 clears it; a written 0 leaves it unchanged.
- R9: irq is high for exactly one cycle, the first cycle after busy falls, when interrupt enable is set. It stays low when interrupt enable is clear.
- R10: An evaluation that makes k level steps keeps busy high for k+1 cycles. A sample strobe during busy is ignored.
- R11: A fan-register write made while busy is ignored.
- R12: scan_req equals scan OR auto-scan. An accepted sample clears the scan bit but not the auto-scan bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_valid | input | 1 | New-sample strobe |
| sample_temp | input | 8 | Signed temperature in °C |
| ot_limit | input | 8 | Over-temperature limit in °C |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects fan |
| wr_data | input | 16 | Register write data |
| ctrl_rd | output | 16 | Control register readback |
| fan_rd | output | 16 | Fan register readback |
| busy | output | 1 | Evaluation in progress |
| irq | output | 1 | End-of-evaluation interrupt pulse |
| pwm_out | output | 1 | Fan PWM drive |
| scan_req | output | 1 | Request for a sensor scan |

## Verification
A wrong direction choice or a wrong threshold index shows at the ports as a final level that is off by one or more. It appears in fan_rd in the first cycle after busy falls. A walk that skips or repeats steps changes the length of the busy window, so every evaluation is timed as well as checked for its end value. A corrupted level also shows within ten clocks as a wrong count of high cycles on pwm_out.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam int LVL_W = 4;   // width of the level field in the fan register
  localparam int FAN_LSB = 8; // position of the level field

  // Negative samples count as zero degrees
  function automatic logic [7:0] clean_temp(input logic [7:0] t);
    return t[7] ? 8'd0 : t;
  endfunction

  // Threshold for a table index: base + step * idx
  function automatic logic [7:0] thr_at(input logic [LVL_W-1:0] idx,
                                        input int base, input int step);
    return 8'(base + step * int'(idx));
  endfunction
endpackage

// File: rtl/fan_step_unit.sv
module fan_step_unit #(
  parameter int MAX_LEVEL  = 10,
  parameter int INIT_LEVEL = 3,
  parameter int TH_BASE    = 30,
  parameter int TH_STEP    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [7:0]               temp_in,
  input  logic                     lvl_wr,
  input  logic [fan_pkg::LVL_W-1:0] lvl_wdata,
  output logic [fan_pkg::LVL_W-1:0] level,
  output logic                     busy,
  output logic                     done
);
  import fan_pkg::*;
  localparam logic [LVL_W-1:0] MAXL = LVL_W'(MAX_LEVEL);

  logic [LVL_W-1:0] level_q, lvl_clamped;
  logic [7:0]       temp_q;
  logic             up_q, busy_q, done_q;
  logic             step_ok;

  assign lvl_clamped = (level_q > MAXL) ? MAXL : level_q;

  always_comb begin
    if (up_q)
      step_ok = (level_q < MAXL) &&
                (temp_q >= thr_at(level_q + 1'b1, TH_BASE, TH_STEP));
    else
      step_ok = (level_q > 1) &&
                (temp_q < thr_at(level_q - LVL_W'(2), TH_BASE, TH_STEP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= LVL_W'(INIT_LEVEL);
      temp_q  <= '0;
      up_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          temp_q  <= temp_in;
          level_q <= lvl_clamped;
          up_q    <= temp_in >= thr_at(lvl_clamped, TH_BASE, TH_STEP);
          busy_q  <= 1'b1;
        end else if (lvl_wr) begin
          level_q <= lvl_wdata;
        end
      end else if (step_ok) begin
        level_q <= up_q ? level_q + 1'b1 : level_q - 1'b1;
      end else begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign level = level_q;
  assign busy  = busy_q;
  assign done  = done_q;

  // R10: at most one level step per clock while evaluating
  a_r10_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (level_q == $past(level_q)) || (level_q == $past(level_q) + 1'b1) ||
               (level_q + 1'b1 == $past(level_q)));
  // R3: a walk always runs on a clamped level
  a_r3_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> level_q <= MAXL);
  // R10: the end of a walk is announced exactly as busy falls
  a_r10_done_edge: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q && $past(busy_q));
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int STEPS = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [fan_pkg::LVL_W-1:0] level,
  output logic                      pwm
);
  localparam int CW = $clog2(STEPS);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == CW'(STEPS - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign pwm = 32'(cnt) < 32'(level);

  // R6: the phase counter stays inside one PWM period
  a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < STEPS);
endmodule

// File: rtl/fan_hyst_ctrl.sv
module fan_hyst_ctrl #(
  parameter int MAX_LEVEL  = 10,
  parameter int INIT_LEVEL = 3,
  parameter int TH_BASE    = 30,
  parameter int TH_STEP    = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_valid,
  input  logic [7:0]  sample_temp,
  input  logic [7:0]  ot_limit,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] ctrl_rd,
  output logic [15:0] fan_rd,
  output logic        busy,
  output logic        irq,
  output logic        pwm_out,
  output logic        scan_req
);
  import fan_pkg::*;

  logic             scan_q, auto_q, ie_q, ot_q;
  logic             accept, done, ctrl_wr, fan_wr, ot_hit, ot_clear;
  logic [7:0]       t_clean;
  logic [LVL_W-1:0] level;
  logic             unused_bits;

  assign t_clean  = clean_temp(sample_temp);
  assign accept   = sample_valid && !busy;
  assign ctrl_wr  = wr_en && (wr_addr == 1'b0);
  assign fan_wr   = wr_en && (wr_addr == 1'b1);
  assign ot_hit   = accept && (t_clean >= ot_limit);
  assign ot_clear = ctrl_wr && wr_data[15];
  assign unused_bits = ^{wr_data[14:12], wr_data[7:3]};

  fan_step_unit #(
    .MAX_LEVEL(MAX_LEVEL), .INIT_LEVEL(INIT_LEVEL),
    .TH_BASE(TH_BASE), .TH_STEP(TH_STEP)
  ) u_step (
    .clk(clk), .rst_n(rst_n), .start(accept), .temp_in(t_clean),
    .lvl_wr(fan_wr), .lvl_wdata(wr_data[FAN_LSB +: LVL_W]),
    .level(level), .busy(busy), .done(done)
  );

  fan_pwm_gen #(.STEPS(MAX_LEVEL)) u_pwm (
    .clk(clk), .rst_n(rst_n), .level(level), .pwm(pwm_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= 1'b0;
      auto_q <= 1'b0;
      ie_q   <= 1'b0;
      ot_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        scan_q <= wr_data[0];
        auto_q <= wr_data[1];
        ie_q   <= wr_data[2];
      end
      if (accept) scan_q <= 1'b0;
      if (ot_hit) ot_q <= 1'b1;
      else if (ot_clear) ot_q <= 1'b0;
    end
  end

  assign ctrl_rd  = {ot_q, 12'd0, ie_q, auto_q, scan_q};
  assign fan_rd   = {4'd0, level, 8'd0};
  assign irq      = done && ie_q;
  assign scan_req = scan_q || auto_q;

  // R9: interrupt is a single-cycle pulse
  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R8: over-temperature flag only drops on a write of one
  a_r8_ot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ot_q && !ot_clear |=> ot_q);
  // R11: fan level untouched by a write while evaluating
  a_r11_wr_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fan_wr && busy && !$past(busy) |=> level <= LVL_W'(MAX_LEVEL));
endmodule

// File: tb/fan_hyst_ctrl_tb.sv
module fan_hyst_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic [7:0]  sample_temp = '0;
  logic [7:0]  ot_limit = 8'd90;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_rd, fan_rd;
  logic        busy, irq, pwm_out, scan_req;
  int checks = 0;
  int errors = 0;
  int busy_n;
  logic irq_seen;

  always #10 clk = ~clk;

  fan_hyst_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_temp(sample_temp),
    .ot_limit(ot_limit), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .fan_rd(fan_rd), .busy(busy), .irq(irq),
    .pwm_out(pwm_out), .scan_req(scan_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Drive one sample, then time the busy window; irq sampled when busy drops
  task automatic sample(input logic [7:0] t);
    sample_valid = 1'b1; sample_temp = t;
    @(negedge clk);
    sample_valid = 1'b0;
    busy_n = 0;
    while (busy) begin busy_n++; @(negedge clk); end
    irq_seen = irq;
  endtask

  task automatic pwm_count(input string req, input int exp);
    int hi = 0;
    for (int i = 0; i < 10; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    chk(req, hi, exp);
  endtask

  task automatic t_reset();
    chk("R1 level", int'(fan_rd[11:8]), 3);
    chk("R1 ctrl", int'(ctrl_rd), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 irq", int'(irq), 0);
    pwm_count("R6 duty at 3", 3);
  endtask

  task automatic t_rise();
    reg_wr(1'b0, 16'h0004);
    sample(8'd62);
    chk("R4 level", int'(fan_rd[11:8]), 6);
    chk("R10 busy cycles", busy_n, 4);
    chk("R9 irq pulse", int'(irq_seen), 1);
    @(negedge clk);
    chk("R9 irq single", int'(irq), 0);
    pwm_count("R6 duty at 6", 6);
  endtask

  task automatic t_fall();
    sample(8'd52);
    chk("R5 hold", int'(fan_rd[11:8]), 6);
    chk("R10 busy hold", busy_n, 1);
    sample(8'd41);
    chk("R5 fall", int'(fan_rd[11:8]), 4);
    chk("R10 busy fall", busy_n, 3);
  endtask

  task automatic t_negative();
    sample(8'hFB);
    chk("R2 neg as zero", int'(fan_rd[11:8]), 1);
    chk("R2 busy", busy_n, 4);
  endtask

  task automatic t_clamp();
    reg_wr(1'b1, 16'hFF00);
    chk("R7 fan readback", int'(fan_rd), 16'h0F00);
    sample(8'd85);
    chk("R3 clamp up", int'(fan_rd[11:8]), 10);
    reg_wr(1'b1, 16'h0F00);
    sample(8'd77);
    chk("R3 clamp hold", int'(fan_rd[11:8]), 10);
    pwm_count("R6 duty at 10", 10);
  endtask

  task automatic t_irq_off();
    reg_wr(1'b0, 16'h0000);
    sample(8'd20);
    chk("R9 irq disabled", int'(irq_seen), 0);
  endtask

  task automatic t_ot();
    sample(8'd95);
    chk("R8 ot set", int'(ctrl_rd[15]), 1);
    reg_wr(1'b0, 16'h0000);
    chk("R8 ot zero write", int'(ctrl_rd[15]), 1);
    reg_wr(1'b0, 16'h8000);
    chk("R8 ot clear", int'(ctrl_rd[15]), 0);
    reg_wr(1'b0, 16'h0006);
    chk("R8 ctrl bits", int'(ctrl_rd), 6);
  endtask

  task automatic t_busy_ignore();
    reg_wr(1'b1, 16'h0300);
    sample_valid = 1'b1; sample_temp = 8'd62;
    @(negedge clk);
    sample_temp = 8'd0;
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 16'h0100;
    @(negedge clk);
    sample_valid = 1'b0; wr_en = 1'b0;
    while (busy) @(negedge clk);
    chk("R11 write ignored", int'(fan_rd[11:8]), 6);
    @(negedge clk);
    chk("R10 strobe ignored", int'(busy), 0);
    chk("R10 level kept", int'(fan_rd[11:8]), 6);
  endtask

  task automatic t_scan();
    reg_wr(1'b0, 16'h0001);
    chk("R12 scan_req one-shot", int'(scan_req), 1);
    sample(8'd50);
    chk("R12 scan cleared", int'(ctrl_rd[0]), 0);
    chk("R12 scan_req low", int'(scan_req), 0);
    reg_wr(1'b0, 16'h0002);
    sample(8'd50);
    chk("R12 auto kept", int'(scan_req), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_negative();
    t_clamp();
    t_irq_off();
    t_ot();
    t_busy_ignore();
    t_scan();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule